// File: doc/BRIEF.md
# Effective Address Generator with Base, Segment and Relative Origins

This block turns the address field of an instruction into a memory address. Each request names one of four address forms. In the absolute form the origin is zero. In the base form the origin is a full-width value from a general-purpose register chosen by the instruction. In the segment form the origin is a 16-bit segment value scaled by sixteen. In the relative form the origin is the program counter and the field is a signed quantity. The block also pulls the register fields out of a fixed 32-bit load-word layout. The surrounding pipeline uses these fields to read the base and index registers. It then presents their values in the same cycle as the request.

The result is registered. A request sampled at a clock edge produces a one-cycle valid pulse on the next cycle, together with the address, the destination register number and the opcode. A relative request whose true target lies below zero or beyond the top of the address space still wraps into range. In that case an error flag is raised beside the address. There is no back-pressure: a request can be accepted on every cycle.

Top module: `addr_xlate`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ea_valid`, `ea`, `ea_range_err`, `ea_dst` and `ea_op` are all zero.
- R2: A request sampled at a rising edge produces `ea_valid` high for the following cycle. `ea_valid` is low after any edge at which `req` was low, so back-to-back requests give a continuous high level.
- R3: The instruction word is split with bit 31 as the most significant bit: opcode in bits 31:24, destination register in 23:20, index register number in 19:16, base register number in 15:12 and displacement in 11:0. `base_sel` and `idx_sel` show bits 15:12 and 19:16 in the same cycle, without a register. `ea_dst` and `ea_op` show bits 23:20 and 31:24 of the accepted word together with its result.
- R4: Mode 0 (absolute): `ea` = (zero-extended displacement + index contribution) modulo 2^AW.
- R5: Mode 1 (base): `ea` = (`base_val` + zero-extended displacement + index contribution) modulo 2^AW. For example, base 0x1C25E0 with displacement 0x37A and no index gives 0x1C295A.
- R6: In modes 0 and 1 the index contribution is `idx_val` when the index field (bits 19:16) is non-zero. When the index field is zero the contribution is zero, whatever `idx_val` holds.
- R7: Mode 2 (segment): `ea` = (`seg_val` × 16 + instruction bits 15:0) modulo 2^20, zero-extended to AW bits. `base_val`, `idx_val` and `pc` have no effect.
- R8: Mode 3 (relative): `ea` = (`pc` + sign-extended bits 11:0) modulo 2^AW. A field of +3 gives 49 at PC 46 and 53 at PC 50.
- R9: `ea_range_err` is high with a result only when the mode was 3 and the true sum of `pc` and the signed field is negative or at least 2^AW. For every other mode it is low.
- R10: While `req` is low, `ea`, `ea_dst` and `ea_op` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, one address per cycle |
| mode | input | 2 | Address form: 0 absolute, 1 base, 2 segment, 3 relative |
| instr | input | 32 | Instruction word |
| base_val | input | AW | Value of the register named by `base_sel` |
| idx_val | input | AW | Value of the register named by `idx_sel` |
| seg_val | input | SEG_W | Segment register value |
| pc | input | AW | Program counter of the instruction |
| base_sel | output | 4 | Base register number taken from the word |
| idx_sel | output | 4 | Index register number taken from the word |
| ea_valid | output | 1 | Result strobe |
| ea | output | AW | Effective address |
| ea_range_err | output | 1 | Relative target outside the address space |
| ea_dst | output | 4 | Destination register number of the accepted word |
| ea_op | output | 8 | Opcode of the accepted word |

## Verification
Two things can happen in the same cycle: the wrap of a relative address and the raising of the range flag. The bench provokes this by sweeping all 4096 signed field values at program counters close to zero and close to the top of the space. For each vector it expects the wrapped address and the flag together, both computed from a true-sum model. A second overlap arises in the base form, where the index addition and the base-register wrap can both occur. This is provoked with a base of all ones, a non-zero index field, and a zero index field paired with a non-zero index value. Those results are judged against arithmetic reduced modulo the address width.

// File: rtl/addr_xlate_pkg.sv
`timescale 1ns/1ps
package addr_xlate_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned DISP_W = 12;
   localparam int unsigned RNUM_W = 4;
   localparam int unsigned OPC_W  = 8;

   typedef enum logic [1:0] {
      XM_ABS  = 2'd0,
      XM_BASE = 2'd1,
      XM_SEG  = 2'd2,
      XM_REL  = 2'd3
   } xmode_e;

   // load-word layout, first member is the most significant
   typedef struct packed {
      logic [OPC_W-1:0]  opc;
      logic [RNUM_W-1:0] dst;
      logic [RNUM_W-1:0] idx;
      logic [RNUM_W-1:0] bas;
      logic [DISP_W-1:0] disp;
   } ldw_t;
endpackage

// File: rtl/addr_field_decode.sv
`timescale 1ns/1ps
module addr_field_decode
   import addr_xlate_pkg::*;
#(
   parameter int unsigned OFF_W = 16
) (
   input  logic [WORD_W-1:0] word,
   output logic [OPC_W-1:0]  opc,
   output logic [RNUM_W-1:0] dst,
   output logic [RNUM_W-1:0] idx_num,
   output logic [RNUM_W-1:0] base_num,
   output logic [DISP_W-1:0] disp,
   output logic [OFF_W-1:0]  seg_off
);
   ldw_t f;

   always_comb begin
      f        = ldw_t'(word);
      opc      = f.opc;
      dst      = f.dst;
      idx_num  = f.idx;
      base_num = f.bas;
      disp     = f.disp;
      seg_off  = word[OFF_W-1:0];
   end
endmodule

// File: rtl/addr_origin_mux.sv
`timescale 1ns/1ps
module addr_origin_mux
   import addr_xlate_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned OFF_W     = 16,
   parameter bit          IDX_EN    = 1'b1,
   localparam int unsigned SW       = AW + 2
) (
   input  xmode_e            m,
   input  logic [AW-1:0]     base_val,
   input  logic [AW-1:0]     idx_val,
   input  logic [SEG_W-1:0]  seg_val,
   input  logic [AW-1:0]     pc,
   input  logic [RNUM_W-1:0] idx_num,
   input  logic [DISP_W-1:0] disp,
   input  logic [OFF_W-1:0]  seg_off,
   output logic [AW-1:0]     origin,
   output logic [SW-1:0]     offs,
   output logic [AW-1:0]     idx_add
);
   logic [AW-1:0] seg_org;

   always_comb begin
      seg_org = {{(AW-SEG_W){1'b0}}, seg_val} << SEG_SHIFT;
      unique case (m)
         XM_ABS: begin
            origin = '0;
            offs   = {{(SW-DISP_W){1'b0}}, disp};
         end
         XM_BASE: begin
            origin = base_val;
            offs   = {{(SW-DISP_W){1'b0}}, disp};
         end
         XM_SEG: begin
            origin = seg_org;
            offs   = {{(SW-OFF_W){1'b0}}, seg_off};
         end
         default: begin
            origin = pc;
            offs   = {{(SW-DISP_W){disp[DISP_W-1]}}, disp};
         end
      endcase
   end

   generate
      if (IDX_EN) begin : g_idx
         always_comb begin
            if ((idx_num != '0) && ((m == XM_ABS) || (m == XM_BASE)))
               idx_add = idx_val;
            else
               idx_add = '0;
         end
      end else begin : g_noidx
         assign idx_add = '0;
      end
   endgenerate
endmodule

// File: rtl/addr_sum_reg.sv
`timescale 1ns/1ps
module addr_sum_reg
   import addr_xlate_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned SEG_AW = 20,
   localparam int unsigned SW    = AW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  xmode_e            m,
   input  logic [AW-1:0]     origin,
   input  logic [SW-1:0]     offs,
   input  logic [AW-1:0]     idx_add,
   input  logic [RNUM_W-1:0] dst,
   input  logic [OPC_W-1:0]  opc,
   output logic              ea_valid,
   output logic [AW-1:0]     ea,
   output logic              ea_range_err,
   output logic [RNUM_W-1:0] ea_dst,
   output logic [OPC_W-1:0]  ea_op
);
   logic [SW-1:0] full;
   logic [AW-1:0] ea_nx;
   logic          err_nx;

   always_comb begin
      full = {2'b00, origin} + offs + {2'b00, idx_add};
      if (m == XM_SEG)
         ea_nx = {{(AW-SEG_AW){1'b0}}, full[SEG_AW-1:0]};
      else
         ea_nx = full[AW-1:0];
      err_nx = (m == XM_REL) && (full[SW-1] || full[AW]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_valid     <= 1'b0;
         ea           <= '0;
         ea_range_err <= 1'b0;
         ea_dst       <= '0;
         ea_op        <= '0;
      end else begin
         ea_valid <= req;
         if (req) begin
            ea           <= ea_nx;
            ea_range_err <= err_nx;
            ea_dst       <= dst;
            ea_op        <= opc;
         end
      end
   end
endmodule

// File: rtl/addr_xlate.sv
`timescale 1ns/1ps
module addr_xlate
   import addr_xlate_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned OFF_W     = 16,
   parameter bit          IDX_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [1:0]        mode,
   input  logic [31:0]       instr,
   input  logic [AW-1:0]     base_val,
   input  logic [AW-1:0]     idx_val,
   input  logic [SEG_W-1:0]  seg_val,
   input  logic [AW-1:0]     pc,
   output logic [3:0]        base_sel,
   output logic [3:0]        idx_sel,
   output logic              ea_valid,
   output logic [AW-1:0]     ea,
   output logic              ea_range_err,
   output logic [3:0]        ea_dst,
   output logic [7:0]        ea_op
);
   localparam int unsigned SEG_AW = SEG_W + SEG_SHIFT;
   localparam int unsigned SW     = AW + 2;

   if (AW <= SEG_AW) begin : g_bad_aw
      $error("addr_xlate: AW must exceed the segment address width");
   end
   if (AW <= DISP_W) begin : g_bad_disp
      $error("addr_xlate: AW must exceed the displacement width");
   end
   if ((OFF_W < DISP_W) || (OFF_W > 20)) begin : g_bad_off
      $error("addr_xlate: OFF_W must lie between 12 and 20");
   end

   xmode_e              m;
   logic [OPC_W-1:0]    opc;
   logic [RNUM_W-1:0]   dst;
   logic [DISP_W-1:0]   disp;
   logic [OFF_W-1:0]    seg_off;
   logic [AW-1:0]       origin;
   logic [SW-1:0]       offs;
   logic [AW-1:0]       idx_add;

   assign m = xmode_e'(mode);

   addr_field_decode #(.OFF_W(OFF_W)) u_dec (
      .word     (instr),
      .opc      (opc),
      .dst      (dst),
      .idx_num  (idx_sel),
      .base_num (base_sel),
      .disp     (disp),
      .seg_off  (seg_off)
   );

   addr_origin_mux #(
      .AW(AW), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT),
      .OFF_W(OFF_W), .IDX_EN(IDX_EN)
   ) u_mux (
      .m        (m),
      .base_val (base_val),
      .idx_val  (idx_val),
      .seg_val  (seg_val),
      .pc       (pc),
      .idx_num  (idx_sel),
      .disp     (disp),
      .seg_off  (seg_off),
      .origin   (origin),
      .offs     (offs),
      .idx_add  (idx_add)
   );

   addr_sum_reg #(.AW(AW), .SEG_AW(SEG_AW)) u_sum (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req),
      .m            (m),
      .origin       (origin),
      .offs         (offs),
      .idx_add      (idx_add),
      .dst          (dst),
      .opc          (opc),
      .ea_valid     (ea_valid),
      .ea           (ea),
      .ea_range_err (ea_range_err),
      .ea_dst       (ea_dst),
      .ea_op        (ea_op)
   );
endmodule

// File: rtl/addr_xlate_chk.sv
`timescale 1ns/1ps
module addr_xlate_chk #(
   parameter int unsigned AW     = 32,
   parameter int unsigned SEG_AW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req,
   input logic [1:0]    mode,
   input logic [3:0]    word_dst,
   input logic          ea_valid,
   input logic [AW-1:0] ea,
   input logic          ea_range_err,
   input logic [3:0]    ea_dst
);
   assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> ea_valid);

   assert_no_valid_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !ea_valid);

   assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> ($stable(ea) && $stable(ea_dst)));

   assert_dst_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> (ea_dst == $past(word_dst)));

   assert_err_only_relative_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && (mode != 2'd3)) |=> !ea_range_err);

   assert_seg_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req && (mode == 2'd2)) |=> ((ea >> SEG_AW) == '0));
endmodule

bind addr_xlate addr_xlate_chk #(.AW(AW), .SEG_AW(SEG_W + SEG_SHIFT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req          (req),
   .mode         (mode),
   .word_dst     (instr[23:20]),
   .ea_valid     (ea_valid),
   .ea           (ea),
   .ea_range_err (ea_range_err),
   .ea_dst       (ea_dst)
);

// File: tb/addr_xlate_tb.sv
`timescale 1ns/1ps
module addr_xlate_tb;
   localparam int unsigned AW = 24;
   localparam longint MASK = (64'd1 << AW) - 1;
   localparam longint SMASK = (64'd1 << 20) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [1:0]    mode = '0;
   logic [31:0]   instr = '0;
   logic [AW-1:0] base_val = '0;
   logic [AW-1:0] idx_val = '0;
   logic [15:0]   seg_val = '0;
   logic [AW-1:0] pc = '0;
   logic [3:0]    base_sel, idx_sel, ea_dst;
   logic          ea_valid, ea_range_err;
   logic [AW-1:0] ea;
   logic [7:0]    ea_op;

   int nvec = 0;
   int nbad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   addr_xlate #(.AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .instr(instr),
      .base_val(base_val), .idx_val(idx_val), .seg_val(seg_val), .pc(pc),
      .base_sel(base_sel), .idx_sel(idx_sel), .ea_valid(ea_valid), .ea(ea),
      .ea_range_err(ea_range_err), .ea_dst(ea_dst), .ea_op(ea_op)
   );

   function automatic logic [31:0] mkw(input logic [7:0] op, input logic [3:0] d,
                                       input logic [3:0] x, input logic [3:0] b,
                                       input logic [11:0] disp);
      return {op, d, x, b, disp};
   endfunction

   task automatic model(input logic [1:0] md, input logic [31:0] w,
                        input longint bv, input longint iv, input longint sv,
                        input longint pcv, output longint e, output bit er);
      longint d, ix, sd, t;
      d  = longint'(w[11:0]);
      ix = (w[19:16] != 4'd0) ? iv : 0;
      er = 1'b0;
      case (md)
         2'd0: e = (d + ix) & MASK;
         2'd1: e = (bv + d + ix) & MASK;
         2'd2: e = (sv * 16 + longint'(w[15:0])) & SMASK;
         default: begin
            sd = (d >= 2048) ? d - 4096 : d;
            t  = pcv + sd;
            er = (t < 0) || (t > MASK);
            e  = t & MASK;
         end
      endcase
   endtask

   // one request; checked on the cycle after the accepting edge
   task automatic apply(input string tag, input logic [1:0] md, input logic [31:0] w,
                        input longint bv, input longint iv, input longint sv,
                        input longint pcv);
      longint e;
      bit er;
      logic [3:0] bs, xs;
      model(md, w, bv, iv, sv, pcv, e, er);
      req = 1'b1; mode = md; instr = w;
      base_val = bv[AW-1:0]; idx_val = iv[AW-1:0]; seg_val = sv[15:0]; pc = pcv[AW-1:0];
      #1;
      bs = base_sel; xs = idx_sel;
      @(posedge clk);
      @(negedge clk);
      nvec++;
      if (!ea_valid || ea != e[AW-1:0] || ea_range_err != er || ea_dst != w[23:20] ||
          ea_op != w[31:24] || bs != w[15:12] || xs != w[19:16]) begin
         nbad++;
         $display("FAIL %s (R2/R3) mode=%0d w=%h: got v=%b ea=%h err=%b dst=%h op=%h bsel=%h xsel=%h, exp v=1 ea=%h err=%b dst=%h op=%h bsel=%h xsel=%h",
                  tag, md, w, ea_valid, ea, ea_range_err, ea_dst, ea_op, bs, xs,
                  e[AW-1:0], er, w[23:20], w[31:24], w[15:12], w[19:16]);
      end
   endtask

   // R10 / R2: idle cycle with changed inputs must not disturb the result
   task automatic idle_check();
      logic [AW-1:0] e0;
      logic [3:0] d0;
      logic [7:0] o0;
      e0 = ea; d0 = ea_dst; o0 = ea_op;
      req = 1'b0; mode = 2'd1; instr = 32'hA5A5_5A5A;
      base_val = 24'h123456; idx_val = 24'h00FF00; pc = 24'h777777; seg_val = 16'hBEEF;
      @(posedge clk);
      @(negedge clk);
      nvec++;
      if (ea_valid || ea != e0 || ea_dst != d0 || ea_op != o0) begin
         nbad++;
         $display("FAIL R10 idle: got v=%b ea=%h dst=%h op=%h, exp v=0 ea=%h dst=%h op=%h",
                  ea_valid, ea, ea_dst, ea_op, e0, d0, o0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      nvec++;
      if (ea_valid || ea != '0 || ea_range_err || ea_dst != '0 || ea_op != '0) begin
         nbad++;
         $display("FAIL R1 in reset: got v=%b ea=%h err=%b dst=%h op=%h, exp all zero",
                  ea_valid, ea, ea_range_err, ea_dst, ea_op);
      end
      rst_n = 1'b1;
      @(negedge clk);
      nvec++;
      if (ea_valid || ea != '0 || ea_range_err || ea_dst != '0 || ea_op != '0) begin
         nbad++;
         $display("FAIL R1 after release: got v=%b ea=%h err=%b, exp zero",
                  ea_valid, ea, ea_range_err);
      end

      // R5 worked example and R3 field positions
      apply("R5 example", 2'd1, mkw(8'h58, 4'h6, 4'h0, 4'h3, 12'h37A), 64'h1C25E0, 64'h5, 0, 0);
      nvec++;
      if (ea != 24'h1C295A) begin
         nbad++;
         $display("FAIL R5 example: got %h exp 1c295a", ea);
      end
      idle_check();

      // R8 worked examples
      apply("R8 pc46", 2'd3, mkw(8'h11, 4'h2, 4'h0, 4'h0, 12'd3), 0, 0, 0, 46);
      nvec++;
      if (ea != 24'd49) begin nbad++; $display("FAIL R8 pc46: got %0d exp 49", ea); end
      apply("R8 pc50", 2'd3, mkw(8'h11, 4'h2, 4'h0, 4'h0, 12'd3), 0, 0, 0, 50);
      nvec++;
      if (ea != 24'd53) begin nbad++; $display("FAIL R8 pc50: got %0d exp 53", ea); end
      idle_check();

      // R4 / R5 / R6 displacement sweeps, back to back
      for (int dsp = 0; dsp < 4096; dsp++) begin
         apply("R4 abs", 2'd0, mkw(8'(dsp), 4'(dsp >> 3), 4'(dsp), 4'(dsp >> 8), 12'(dsp)),
               64'h3333, 64'hFFF000 + dsp, 0, 0);
         apply("R5 base wrap", 2'd1, mkw(8'h58, 4'h1, 4'h0, 4'hF, 12'(dsp)),
               64'hFFFFFF - dsp / 2, 64'h00ABCD, 0, 0);
         apply("R6 index", 2'd1, mkw(8'h5A, 4'h7, 4'(1 + dsp % 15), 4'h2, 12'(dsp)),
               64'hFFF800, 64'(dsp * 977), 0, 0);
      end
      idle_check();

      // R7 segment sweep, other origins must not matter
      foreach (seg_list[k]) begin
         for (int off = 0; off < 65536; off += 257) begin
            apply("R7 seg", 2'd2, {8'h8E, 4'h3, 20'(off)}, 64'hFFFFFF, 64'hFFFFFF, seg_list[k], 64'h9ABCDE);
         end
         apply("R7 seg top", 2'd2, {8'h8E, 4'h3, 20'hFFFF}, 0, 0, seg_list[k], 0);
      end
      idle_check();

      // R8 / R9 full signed sweep at edge and mid program counters
      foreach (pc_list[k]) begin
         for (int dsp = 0; dsp < 4096; dsp++) begin
            apply("R8/R9 rel", 2'd3, mkw(8'h47, 4'h4, 4'hF, 4'hF, 12'(dsp)),
                  64'h111111, 64'h222222, 16'h3333, pc_list[k]);
         end
      end
      idle_check();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   longint seg_list [5] = '{0, 1, 64'h1234, 64'h8000, 64'hFFFF};
   longint pc_list  [6] = '{0, 46, 64'h7FF, 64'h800000, 64'hFFF800, 64'hFFFFFF};
endmodule